// File: doc/BRIEF.md
# Interleaved Triple Timer Register Interface

This block is the register front end for three timer channels that share a single address window. Every kind of register has three neighbouring 32-bit words, one word for each channel, so consecutive words cycle through the channels. The word index (byte address shifted right by two) divided by three gives the register kind, and the remainder gives the channel. The counting logic sits outside this block. It receives each channel's settings from this block and sends back its remaining count, its event count and pulses that set interrupt status bits.

Bus access is single-cycle, with an address, a read strobe, a write strobe and write data. Read data is registered and is valid on the clock edge that follows the request. Interrupt status is sticky. A read returns the status and then clears it. A write clears each bit where the data holds a one. Each channel drives its own interrupt line from its status and enable registers.

Top module: `tri_timer_regs`

## Requirements
- R1: Word index w = addr >> 2 selects channel w mod 3 and register kind w div 3. The kinds in order are: 0 clock control, 1 counter control, 2 counter value, 3 interval, 4..6 match A/B/C, 7 interrupt status, 8 interrupt enable, 9 event control, 10 event value.
- R2: Writes keep only the low bits. Clock control, counter control and interrupt enable keep 6 bits, interval and match keep 16 bits, and event control keeps 3 bits. A read returns the stored value zero-extended. The configuration outputs change only after a write.
- R3: Read data appears on `bus_rdata` the cycle after `bus_rd`. It is 0 for word indices of 33 and above, and 0 in any cycle with no read.
- R4: Writes to unmapped words, to counter value or to event value change no register.
- R5: A one on any bit of a channel's `st_set` sets that status bit, and the bit stays set until it is cleared.
- R6: Reading interrupt status returns the current bits and clears them. A set that arrives in the same cycle as that read is kept and shows on the next read.
- R7: Writing interrupt status clears exactly the bits where write data bit [5:0] is 1.
- R8: `irq[c]` is high when any status bit of channel c is set together with the matching enable bit. It changes only after a bus access or a status set.
- R9: Counter value reads return the remaining count when counter control bit 2 (count down) is 1. Otherwise they return limit minus remaining, where the limit is the interval when bit 1 (interval mode) is 1 and 0xFFFF when it is 0.
- R10: After reset, counter control reads 0x21, every other register reads 0, and `irq` is low.
- R11: Event value reads return the channel's `ev_count` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| st_set | input | 3*6 | Status set pulses, 6 bits per channel |
| cnt_remain | input | 3*CNT_W | Remaining count per channel |
| ev_count | input | 3*CNT_W | Event count per channel |
| cfg_clk | output | 3*6 | Clock control per channel |
| cfg_cnt | output | 3*6 | Counter control per channel |
| cfg_interval | output | 3*CNT_W | Interval per channel |
| cfg_match | output | 3*3*CNT_W | Match A/B/C per channel |
| cfg_evctl | output | 3*3 | Event control per channel |
| irq | output | 3 | Interrupt per channel |

## Verification
Read data belongs to the rising edge that follows the read strobe. The bench therefore queues each expected read word when it issues the read and compares the word at the falling edge one cycle later. Configuration outputs and interrupt lines change on the edge that takes a write or a status pulse, and the bench checks them at the falling edge just after that edge. The coincident set-and-read case expects the old status on the first read and the new bit on the read after it.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;
   localparam int CTL_W   = 6;
   localparam int STS_W   = 6;
   localparam int EVC_W   = 3;
   localparam int N_MATCH = 3;
   localparam int NUM_GRP = 11;
   localparam int BIT_INTERVAL = 1;
   localparam int BIT_DOWN     = 2;
   localparam logic [CTL_W-1:0] CTL_RST_VAL = 6'h21;

   typedef enum logic [3:0] {
      GRP_CLK = 4'd0, GRP_CTL = 4'd1, GRP_VAL = 4'd2, GRP_IVL = 4'd3,
      GRP_MA  = 4'd4, GRP_MB  = 4'd5, GRP_MC  = 4'd6, GRP_STS = 4'd7,
      GRP_IEN = 4'd8, GRP_EVC = 4'd9, GRP_EVV = 4'd10
   } reg_grp_e;
endpackage

// File: rtl/ttr_decode.sv
module ttr_decode
   import tri_timer_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int NUM_CH = 3,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_grp_e          grp,
   output logic [CH_W-1:0]   ch,
   output logic              hit
);
   localparam int WORD_W = ADDR_W - 2;

   if (WORD_W < 6) begin : g_bad_addr
      $error("ttr_decode: ADDR_W too small for the register window");
   end

   logic [WORD_W-1:0] word, grp_idx, ch_idx;

   always_comb begin
      word    = addr[ADDR_W-1:2];
      grp_idx = word / WORD_W'(NUM_CH);
      ch_idx  = word % WORD_W'(NUM_CH);
      hit     = (grp_idx < WORD_W'(NUM_GRP));
      ch      = ch_idx[CH_W-1:0];
      grp     = hit ? reg_grp_e'(grp_idx[3:0]) : GRP_CLK;
   end
endmodule

// File: rtl/ttr_channel.sv
module ttr_channel
   import tri_timer_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic                     rd_en,
   input  reg_grp_e                 grp,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [STS_W-1:0]         sts_set,
   input  logic [CNT_W-1:0]         remain,
   input  logic [CNT_W-1:0]         ev_count,
   output logic [CTL_W-1:0]         clk_ctrl,
   output logic [CTL_W-1:0]         cnt_ctrl,
   output logic [CNT_W-1:0]         interval,
   output logic [N_MATCH*CNT_W-1:0] match,
   output logic [EVC_W-1:0]         ev_ctrl,
   output logic [DATA_W-1:0]        rdata,
   output logic                     irq
);
   if (DATA_W < CNT_W) begin : g_bad_width
      $error("ttr_channel: DATA_W must hold a count");
   end

   logic [STS_W-1:0] sts_q, ien_q, sts_d;
   logic [CNT_W-1:0] limit, live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_ctrl <= '0;
         cnt_ctrl <= CTL_RST_VAL;
         interval <= '0;
         ien_q    <= '0;
         ev_ctrl  <= '0;
      end else if (wr_en) begin
         case (grp)
            GRP_CLK: clk_ctrl <= wdata[CTL_W-1:0];
            GRP_CTL: cnt_ctrl <= wdata[CTL_W-1:0];
            GRP_IVL: interval <= wdata[CNT_W-1:0];
            GRP_IEN: ien_q    <= wdata[STS_W-1:0];
            GRP_EVC: ev_ctrl  <= wdata[EVC_W-1:0];
            default: ;
         endcase
      end
   end

   for (genvar m = 0; m < N_MATCH; m++) begin : g_match
      localparam logic [3:0] MGRP = 4'(GRP_MA) + 4'(m);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            match[m*CNT_W +: CNT_W] <= '0;
         else if (wr_en && (4'(grp) == MGRP))
            match[m*CNT_W +: CNT_W] <= wdata[CNT_W-1:0];
      end
   end

   always_comb begin
      if (wr_en && grp == GRP_STS)
         sts_d = (sts_q & ~wdata[STS_W-1:0]) | sts_set;
      else if (rd_en && grp == GRP_STS)
         sts_d = sts_set;
      else
         sts_d = sts_q | sts_set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q <= '0;
      else        sts_q <= sts_d;
   end

   always_comb begin
      limit = cnt_ctrl[BIT_INTERVAL] ? interval : {CNT_W{1'b1}};
      live  = cnt_ctrl[BIT_DOWN] ? remain : (limit - remain);
   end

   always_comb begin
      case (grp)
         GRP_CLK: rdata = DATA_W'(clk_ctrl);
         GRP_CTL: rdata = DATA_W'(cnt_ctrl);
         GRP_VAL: rdata = DATA_W'(live);
         GRP_IVL: rdata = DATA_W'(interval);
         GRP_MA:  rdata = DATA_W'(match[0*CNT_W +: CNT_W]);
         GRP_MB:  rdata = DATA_W'(match[1*CNT_W +: CNT_W]);
         GRP_MC:  rdata = DATA_W'(match[2*CNT_W +: CNT_W]);
         GRP_STS: rdata = DATA_W'(sts_q);
         GRP_IEN: rdata = DATA_W'(ien_q);
         GRP_EVC: rdata = DATA_W'(ev_ctrl);
         GRP_EVV: rdata = DATA_W'(ev_count);
         default: rdata = '0;
      endcase
   end

   assign irq = |(sts_q & ien_q);
endmodule

// File: rtl/tri_timer_regs.sv
module tri_timer_regs
   import tri_timer_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [ADDR_W-1:0]               bus_addr,
   input  logic                            bus_rd,
   input  logic                            bus_wr,
   input  logic [DATA_W-1:0]               bus_wdata,
   output logic [DATA_W-1:0]               bus_rdata,
   input  logic [NUM_CH*STS_W-1:0]         st_set,
   input  logic [NUM_CH*CNT_W-1:0]         cnt_remain,
   input  logic [NUM_CH*CNT_W-1:0]         ev_count,
   output logic [NUM_CH*CTL_W-1:0]         cfg_clk,
   output logic [NUM_CH*CTL_W-1:0]         cfg_cnt,
   output logic [NUM_CH*CNT_W-1:0]         cfg_interval,
   output logic [NUM_CH*N_MATCH*CNT_W-1:0] cfg_match,
   output logic [NUM_CH*EVC_W-1:0]         cfg_evctl,
   output logic [NUM_CH-1:0]               irq
);
   localparam int CH_W = $clog2(NUM_CH);

   if (NUM_CH != 3) begin : g_bad_ch
      $error("tri_timer_regs: the interleaved map serves exactly three channels");
   end

   reg_grp_e          dec_grp;
   logic [CH_W-1:0]   dec_ch;
   logic              dec_hit;
   logic [DATA_W-1:0] ch_rdata [NUM_CH];
   logic [DATA_W-1:0] rd_mux;

   ttr_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
      .addr(bus_addr), .grp(dec_grp), .ch(dec_ch), .hit(dec_hit)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic sel;
      assign sel = dec_hit && (dec_ch == CH_W'(c));
      ttr_channel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (bus_wr && sel),
         .rd_en    (bus_rd && sel),
         .grp      (dec_grp),
         .wdata    (bus_wdata),
         .sts_set  (st_set[c*STS_W +: STS_W]),
         .remain   (cnt_remain[c*CNT_W +: CNT_W]),
         .ev_count (ev_count[c*CNT_W +: CNT_W]),
         .clk_ctrl (cfg_clk[c*CTL_W +: CTL_W]),
         .cnt_ctrl (cfg_cnt[c*CTL_W +: CTL_W]),
         .interval (cfg_interval[c*CNT_W +: CNT_W]),
         .match    (cfg_match[c*N_MATCH*CNT_W +: N_MATCH*CNT_W]),
         .ev_ctrl  (cfg_evctl[c*EVC_W +: EVC_W]),
         .rdata    (ch_rdata[c]),
         .irq      (irq[c])
      );
   end

   always_comb begin
      rd_mux = '0;
      for (int c = 0; c < NUM_CH; c++)
         if (dec_hit && bus_rd && dec_ch == CH_W'(c)) rd_mux = ch_rdata[c];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= rd_mux;
   end
endmodule

// File: rtl/ttr_checker.sv
module ttr_checker
   import tri_timer_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 3
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic [ADDR_W-1:0]               bus_addr,
   input logic                            bus_rd,
   input logic                            bus_wr,
   input logic [DATA_W-1:0]               bus_rdata,
   input logic [NUM_CH*STS_W-1:0]         st_set,
   input logic [NUM_CH*CTL_W-1:0]         cfg_clk,
   input logic [NUM_CH*CTL_W-1:0]         cfg_cnt,
   input logic [NUM_CH*CNT_W-1:0]         cfg_interval,
   input logic [NUM_CH*N_MATCH*CNT_W-1:0] cfg_match,
   input logic [NUM_CH*EVC_W-1:0]         cfg_evctl,
   input logic [NUM_CH-1:0]               irq
);
   logic unmapped;
   assign unmapped = (int'(bus_addr[ADDR_W-1:2]) >= NUM_GRP * NUM_CH);

   assert_rdata_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> bus_rdata == '0);

   assert_unmapped_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && unmapped) |=> bus_rdata == '0);

   assert_unmapped_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && unmapped) |=> ($stable(cfg_clk) && $stable(cfg_cnt) &&
         $stable(cfg_interval) && $stable(cfg_match) && $stable(cfg_evctl)));

   assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> ($stable(cfg_clk) && $stable(cfg_cnt) &&
         $stable(cfg_interval) && $stable(cfg_match) && $stable(cfg_evctl)));

   assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr && !bus_rd && st_set == '0) |=> $stable(irq));
endmodule

bind tri_timer_regs ttr_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_CH(NUM_CH)
) u_ttr_checker (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
   .bus_wr(bus_wr), .bus_rdata(bus_rdata), .st_set(st_set),
   .cfg_clk(cfg_clk), .cfg_cnt(cfg_cnt), .cfg_interval(cfg_interval),
   .cfg_match(cfg_match), .cfg_evctl(cfg_evctl), .irq(irq)
);

// File: tb/tri_timer_regs_bench.sv
module tri_timer_regs_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic [17:0] st_set = '0;
   logic [47:0] cnt_remain = '0, ev_count = '0;
   logic [17:0] cfg_clk, cfg_cnt;
   logic [47:0] cfg_interval;
   logic [143:0] cfg_match;
   logic [8:0]  cfg_evctl;
   logic [2:0]  irq;

   int checks = 0, errors = 0;
   bit done = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_q = 1'b0;

   always #4 clk = ~clk;

   tri_timer_regs u_tri_timer_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .st_set(st_set), .cnt_remain(cnt_remain), .ev_count(ev_count),
      .cfg_clk(cfg_clk), .cfg_cnt(cfg_cnt), .cfg_interval(cfg_interval),
      .cfg_match(cfg_match), .cfg_evctl(cfg_evctl), .irq(irq)
   );

   function automatic logic [11:0] ra(int kind, int ch);
      return 12'((kind * 3 + ch) * 4);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: a read taken at one edge is compared at the following falling edge
   always @(posedge clk) rd_q <= bus_rd;
   always @(negedge clk) begin
      if (rd_q && rst_n) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R3 actual=unexpected read expected=none");
         end else begin
            chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
         end
      end
   end

   task automatic wr(logic [11:0] a, logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, logic [31:0] e, string tag);
      exp_q.push_back(e); tag_q.push_back(tag);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 irq", 32'(irq), 32'h0);
      for (int c = 0; c < 3; c++) rd(ra(1, c), 32'h21, "R10 cnt ctrl");
      rd(ra(3, 1), 32'h0, "R10 interval");
      rd(ra(8, 2), 32'h0, "R10 int enable");
      // R1 R2 decode and masking
      wr(ra(3, 1), 32'hABCD_1234);
      chk("R1 interval ch1 out", 32'(cfg_interval[31:16]), 32'h1234);
      chk("R1 interval ch0 out", 32'(cfg_interval[15:0]), 32'h0);
      rd(ra(3, 1), 32'h1234, "R2 interval mask");
      wr(ra(0, 2), 32'hFF);
      rd(ra(0, 2), 32'h3F, "R2 clock ctrl mask");
      wr(ra(9, 0), 32'hFF);
      chk("R2 event ctrl out", 32'(cfg_evctl[2:0]), 32'h7);
      wr(ra(5, 0), 32'h1_5555);
      wr(ra(6, 2), 32'h7777);
      rd(ra(5, 0), 32'h5555, "R1 match B ch0");
      rd(ra(6, 2), 32'h7777, "R1 match C ch2");
      chk("R1 match A ch0 untouched", 32'(cfg_match[15:0]), 32'h0);
      chk("R1 match C ch2 out", 32'(cfg_match[96+32 +: 16]), 32'h7777);
      // R3 R4 unmapped and read-only
      wr(12'h084, 32'hFFFF);
      wr(12'hFFC, 32'hFFFF);
      chk("R4 unmapped write", 32'(cfg_interval), 32'h1234_0000);
      rd(12'h084, 32'h0, "R3 unmapped read");
      cnt_remain[15:0] = 16'd100;
      wr(ra(2, 0), 32'h0);
      rd(ra(2, 0), 32'd65435, "R9 free up count");
      // R9 count modes
      wr(ra(3, 0), 32'd1000);
      wr(ra(1, 0), 32'h02);
      rd(ra(2, 0), 32'd900, "R9 interval up count");
      wr(ra(1, 0), 32'h06);
      rd(ra(2, 0), 32'd100, "R9 down count");
      rd(ra(1, 0), 32'h06, "R2 cnt ctrl readback");
      // R11
      ev_count[47:32] = 16'h4242;
      wr(ra(10, 2), 32'h1);
      rd(ra(10, 2), 32'h4242, "R11 event value");
      // R5 R8 R7 R6
      st_set[11:6] = 6'h05;
      @(negedge clk);
      st_set = '0;
      chk("R8 irq disabled", 32'(irq), 32'h0);
      wr(ra(8, 1), 32'h04);
      chk("R8 irq ch1", 32'(irq), 32'h2);
      wr(ra(7, 1), 32'h04);
      chk("R7 irq after w1c", 32'(irq), 32'h0);
      rd(ra(7, 1), 32'h01, "R7 remaining bit");
      rd(ra(7, 1), 32'h00, "R6 cleared by read");
      // R6 coincident set
      exp_q.push_back(32'h0); tag_q.push_back("R6 read before set");
      bus_rd = 1'b1; bus_addr = ra(7, 2); st_set[17:12] = 6'h10;
      @(negedge clk);
      bus_rd = 1'b0; st_set = '0;
      wr(ra(8, 2), 32'h10);
      chk("R5 irq ch2 from kept set", 32'(irq), 32'h4);
      rd(ra(7, 2), 32'h10, "R6 coincident set kept");
      chk("R6 irq after read clear", 32'(irq), 32'h0);
      repeat (3) @(negedge clk);
      chk("R3 all reads returned", 32'(exp_q.size()), 32'h0);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule